// File: doc/BRIEF.md
# Cascaded Secondary Interrupt Controller

This block collects up to 32 level-sensitive interrupt lines and presents them to a primary vectored controller in two ways. Any source can be sent straight to the matching input of the primary controller through a per-source pass-through mask. Every enabled source that is not passed through is merged into a single cascade line. The primary controller raises one shared interrupt for that line, and its handler reads the masked status word to find out which secondary sources are active.

Software controls the enable mask through two write-only strobe registers. One register sets enable bits and the other clears them, so mask updates never need a read-modify-write. A source is acknowledged by clearing its enable bit. Because the inputs are level sensitive, a source that is still held high reasserts as soon as it is enabled again. A fixed group of low-numbered sources can never be passed through and always reaches the primary controller through the cascade line.

Register word offsets: 0 = masked status (read only), 1 = enable set, 2 = enable clear, 3 = pass-through mask. All other offsets are unmapped. Read data is registered and appears one clock after the address is presented.

Top module: `sic_cascade_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, the enable mask and the pass-through mask are all zero, and cascade_o, direct_o and rdata_o are zero, whatever irq_i holds.
- R2: A write to offset 1 sets every enable bit whose write-data bit is 1. Enable bits written with 0 keep their value.
- R3: A write to offset 2 clears every enable bit whose write-data bit is 1. Enable bits written with 0 keep their value. Writing all ones disables every source.
- R4: A read of offset 0 returns irq_i AND the enable mask, one clock after the address is presented.
- R5: Offset 3 holds the pass-through mask and is readable and writable. Bits inside CASCADE_ONLY (default 0x000001FF, sources 0 to 8) always read 0 and cannot be set. The mask changes only on a write to offset 3.
- R6: cascade_o is the registered OR of (irq_i AND enable AND NOT pass-through). It rises on the clock edge after a qualifying input goes high, and not before.
- R7: direct_o is the registered value of irq_i AND the pass-through mask, regardless of the enable mask.
- R8: Reads of offsets 1 and 2 return the current enable mask. Unmapped offsets read as zero, and writes to them change no state.
- R9: Clearing the enable bit of a source that is still held high removes it from the status word and from cascade_o. Setting the bit again while the input is still high brings it back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Register word offset |
| wdata_i | input | N_SRC | Write data |
| we_i | input | 1 | Write strobe, one write per cycle while high |
| rdata_o | output | N_SRC | Registered read data |
| irq_i | input | N_SRC | Level-sensitive interrupt sources |
| cascade_o | output | 1 | Combined interrupt to the primary controller |
| direct_o | output | N_SRC | Per-source lines passed through to the primary controller |

## Verification
The bench builds the block with its defaults: 32 sources, a 4-bit offset and sources 0 to 8 locked to the cascade. With a 4-bit offset the unmapped offsets 4 to 15 can be reached, so unmapped reads and writes are tested. With 32 sources the usual routing value 0xFFD00000 and a top-bit source can be tested; the bench uses bit 20 (passed through) and bit 21 (cascaded). The lock mask lets the bench show that a write of ones to the low pass-through bits is dropped.

// File: rtl/sic_pkg.sv
package sic_pkg;
  localparam int unsigned OFS_STATUS = 0;
  localparam int unsigned OFS_SET    = 1;
  localparam int unsigned OFS_CLR    = 2;
  localparam int unsigned OFS_ROUTE  = 3;
endpackage

// File: rtl/sic_enable_bank.sv
module sic_enable_bank #(
  parameter int unsigned N_SRC = 32
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             set_stb_i,
  input  logic             clr_stb_i,
  input  logic [N_SRC-1:0] bits_i,
  output logic [N_SRC-1:0] en_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        en_o[i] <= 1'b0;
      end else if (set_stb_i && bits_i[i]) begin
        en_o[i] <= 1'b1;
      end else if (clr_stb_i && bits_i[i]) begin
        en_o[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sic_route_reg.sv
module sic_route_reg #(
  parameter int unsigned      N_SRC        = 32,
  parameter logic [N_SRC-1:0] CASCADE_ONLY = '0
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             wr_stb_i,
  input  logic [N_SRC-1:0] bits_i,
  output logic [N_SRC-1:0] route_o
);
  localparam logic [N_SRC-1:0] WRITABLE = ~CASCADE_ONLY;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      route_o <= '0;
    end else if (wr_stb_i) begin
      route_o <= bits_i & WRITABLE;
    end
  end
endmodule

// File: rtl/sic_fanout.sv
module sic_fanout #(
  parameter int unsigned N_SRC = 32
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [N_SRC-1:0] irq_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [N_SRC-1:0] route_i,
  output logic             cascade_o,
  output logic [N_SRC-1:0] direct_o
);
  logic [N_SRC-1:0] pool;

  always_comb pool = irq_i & en_i & ~route_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cascade_o <= 1'b0;
      direct_o  <= '0;
    end else begin
      cascade_o <= |pool;
      direct_o  <= irq_i & route_i;
    end
  end
endmodule

// File: rtl/sic_readback.sv
module sic_readback
  import sic_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_SRC-1:0]  irq_i,
  input  logic [N_SRC-1:0]  en_i,
  input  logic [N_SRC-1:0]  route_i,
  output logic [N_SRC-1:0]  rdata_o
);
  logic [N_SRC-1:0] sel;

  always_comb begin
    sel = '0;
    if (addr_i == ADDR_W'(OFS_STATUS))     sel = irq_i & en_i;
    else if (addr_i == ADDR_W'(OFS_SET))   sel = en_i;
    else if (addr_i == ADDR_W'(OFS_CLR))   sel = en_i;
    else if (addr_i == ADDR_W'(OFS_ROUTE)) sel = route_i;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) rdata_o <= '0;
    else       rdata_o <= sel;
  end
endmodule

// File: rtl/sic_cascade_ctrl.sv
module sic_cascade_ctrl
  import sic_pkg::*;
#(
  parameter int unsigned      N_SRC        = 32,
  parameter int unsigned      ADDR_W       = 4,
  parameter logic [N_SRC-1:0] CASCADE_ONLY = N_SRC'(32'h0000_01FF)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_SRC-1:0]  wdata_i,
  input  logic              we_i,
  output logic [N_SRC-1:0]  rdata_o,
  input  logic [N_SRC-1:0]  irq_i,
  output logic              cascade_o,
  output logic [N_SRC-1:0]  direct_o
);
  logic             set_stb, clr_stb, route_stb;
  logic [N_SRC-1:0] en_mask;
  logic [N_SRC-1:0] route_mask;

  always_comb begin
    set_stb   = we_i && (addr_i == ADDR_W'(OFS_SET));
    clr_stb   = we_i && (addr_i == ADDR_W'(OFS_CLR));
    route_stb = we_i && (addr_i == ADDR_W'(OFS_ROUTE));
  end

  sic_enable_bank #(.N_SRC(N_SRC)) u_enable (
    .clk_i(clk_i), .rst_i(rst_i), .set_stb_i(set_stb), .clr_stb_i(clr_stb),
    .bits_i(wdata_i), .en_o(en_mask)
  );

  sic_route_reg #(.N_SRC(N_SRC), .CASCADE_ONLY(CASCADE_ONLY)) u_route (
    .clk_i(clk_i), .rst_i(rst_i), .wr_stb_i(route_stb),
    .bits_i(wdata_i), .route_o(route_mask)
  );

  sic_fanout #(.N_SRC(N_SRC)) u_fanout (
    .clk_i(clk_i), .rst_i(rst_i), .irq_i(irq_i), .en_i(en_mask),
    .route_i(route_mask), .cascade_o(cascade_o), .direct_o(direct_o)
  );

  sic_readback #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_read (
    .clk_i(clk_i), .rst_i(rst_i), .addr_i(addr_i), .irq_i(irq_i),
    .en_i(en_mask), .route_i(route_mask), .rdata_o(rdata_o)
  );
endmodule

// File: rtl/sic_cascade_ctrl_chk.sv
module sic_cascade_ctrl_chk
  import sic_pkg::*;
#(
  parameter int unsigned      N_SRC        = 32,
  parameter int unsigned      ADDR_W       = 4,
  parameter logic [N_SRC-1:0] CASCADE_ONLY = '0
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [N_SRC-1:0]  wdata_i,
  input logic              we_i,
  input logic [N_SRC-1:0]  rdata_o,
  input logic [N_SRC-1:0]  irq_i,
  input logic              cascade_o,
  input logic [N_SRC-1:0]  direct_o,
  input logic [N_SRC-1:0]  en_i,
  input logic [N_SRC-1:0]  route_i
);
  assert_set_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (we_i && addr_i == ADDR_W'(OFS_SET)) |=> en_i == ($past(en_i) | $past(wdata_i)));

  assert_clr_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (we_i && addr_i == ADDR_W'(OFS_CLR)) |=> en_i == ($past(en_i) & ~$past(wdata_i)));

  assert_status_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (addr_i == ADDR_W'(OFS_STATUS)) |=> rdata_o == ($past(irq_i) & $past(en_i)));

  assert_route_hold_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    !(we_i && addr_i == ADDR_W'(OFS_ROUTE)) |=> $stable(route_i));

  assert_route_lock_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (rdata_o & CASCADE_ONLY & {N_SRC{$past(addr_i) == ADDR_W'(OFS_ROUTE)}}) == '0);

  assert_cascade_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> cascade_o == |($past(irq_i) & $past(en_i) & ~$past(route_i)));

  assert_direct_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> direct_o == ($past(irq_i) & $past(route_i)));
endmodule

bind sic_cascade_ctrl sic_cascade_ctrl_chk #(
  .N_SRC(N_SRC), .ADDR_W(ADDR_W), .CASCADE_ONLY(CASCADE_ONLY)
) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .we_i(we_i), .rdata_o(rdata_o), .irq_i(irq_i), .cascade_o(cascade_o),
  .direct_o(direct_o), .en_i(en_mask), .route_i(route_mask)
);

// File: tb/sic_cascade_ctrl_bench.sv
module sic_cascade_ctrl_bench;
  localparam int unsigned N  = 32;
  localparam int unsigned AW = 4;

  typedef struct packed {
    logic [23:0]   tag;
    logic          we;
    logic [AW-1:0] waddr;
    logic [N-1:0]  wdata;
    logic [N-1:0]  irq;
    logic [AW-1:0] raddr;
    logic [N-1:0]  exp_rd;
    logic          exp_casc;
    logic [N-1:0]  exp_dir;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{"R2 ", 1'b1, 4'd1, 32'h0000_00F0, 32'h0000_0030, 4'd0, 32'h0000_0030, 1'b1, 32'h0},
    '{"R2 ", 1'b1, 4'd1, 32'h0000_0000, 32'h0000_0030, 4'd1, 32'h0000_00F0, 1'b1, 32'h0},
    '{"R3 ", 1'b1, 4'd2, 32'h0000_0010, 32'h0000_0030, 4'd0, 32'h0000_0020, 1'b1, 32'h0},
    '{"R9 ", 1'b1, 4'd2, 32'h0000_0020, 32'h0000_0030, 4'd0, 32'h0000_0000, 1'b0, 32'h0},
    '{"R9 ", 1'b1, 4'd1, 32'h0000_0020, 32'h0000_0030, 4'd0, 32'h0000_0020, 1'b1, 32'h0},
    '{"R5 ", 1'b1, 4'd3, 32'hFFD0_01FF, 32'h0000_0030, 4'd3, 32'hFFD0_0000, 1'b1, 32'h0},
    '{"R7 ", 1'b0, 4'd0, 32'h0,         32'h8000_0020, 4'd0, 32'h0000_0020, 1'b1, 32'h8000_0000},
    '{"R6 ", 1'b1, 4'd1, 32'h8000_0000, 32'h8000_0000, 4'd0, 32'h8000_0000, 1'b0, 32'h8000_0000},
    '{"R3 ", 1'b1, 4'd2, 32'hFFFF_FFFF, 32'h8000_0020, 4'd2, 32'h0000_0000, 1'b0, 32'h8000_0000},
    '{"R8 ", 1'b0, 4'd0, 32'h0,         32'h0000_0000, 4'd7, 32'h0000_0000, 1'b0, 32'h0},
    '{"R8 ", 1'b1, 4'd1, 32'hFFFF_FFFF, 32'h0010_0000, 4'd2, 32'hFFFF_FFFF, 1'b0, 32'h0010_0000},
    '{"R4 ", 1'b0, 4'd0, 32'h0,         32'h0020_0000, 4'd0, 32'h0020_0000, 1'b1, 32'h0},
    '{"R8 ", 1'b1, 4'd5, 32'hFFFF_FFFF, 32'h0000_0000, 4'd3, 32'hFFD0_0000, 1'b0, 32'h0}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [N-1:0]  wdata = '0;
  logic          we = 1'b0;
  logic [N-1:0]  rdata;
  logic [N-1:0]  irq = '0;
  logic          cascade;
  logic [N-1:0]  direct;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  sic_cascade_ctrl u_sic_cascade_ctrl (
    .clk_i(clk), .rst_i(rst), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .irq_i(irq), .cascade_o(cascade), .direct_o(direct)
  );

  task automatic check(input string req, input string what,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state with every input high
    irq = '1;
    repeat (4) @(negedge clk);
    check("R1", "rdata in reset", rdata, '0);
    check("R1", "cascade in reset", {31'b0, cascade}, '0);
    check("R1", "direct in reset", direct, '0);
    rst = 1'b0;
    addr = 4'd0;
    @(posedge clk); #1;
    check("R1", "status after reset", rdata, '0);
    check("R1", "cascade after reset", {31'b0, cascade}, '0);
    check("R1", "direct after reset", direct, '0);
    @(negedge clk);
    irq = '0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      we = VECS[i].we; addr = VECS[i].waddr; wdata = VECS[i].wdata; irq = VECS[i].irq;
      @(negedge clk);
      we = 1'b0; addr = VECS[i].raddr;
      @(posedge clk); #1;
      check(string'(VECS[i].tag), "rdata", rdata, VECS[i].exp_rd);
      check(string'(VECS[i].tag), "cascade", {31'b0, cascade}, {31'b0, VECS[i].exp_casc});
      check(string'(VECS[i].tag), "direct", direct, VECS[i].exp_dir);
    end

    // R6: cascade rises on the edge after a qualifying input, not before.
    // State here: enable all ones, pass-through 0xFFD00000.
    @(negedge clk);
    irq = 32'h0000_0001;
    #1;
    check("R6", "cascade before edge", {31'b0, cascade}, '0);
    @(posedge clk); #1;
    check("R6", "cascade after edge", {31'b0, cascade}, 32'h1);

    // R1: a reset mid-run clears the enable and pass-through masks
    @(negedge clk);
    rst = 1'b1; irq = '1;
    @(negedge clk);
    rst = 1'b0; addr = 4'd1;
    @(posedge clk); #1;
    check("R1", "enable after re-reset", rdata, '0);
    @(negedge clk);
    addr = 4'd3;
    @(posedge clk); #1;
    check("R1", "route after re-reset", rdata, '0);
    check("R1", "cascade after re-reset", {31'b0, cascade}, '0);

    finish_run();
  end
endmodule